// File: doc/BRIEF.md
# Virtual TAP hub discovery sequencer

This block is a hardware master that finds one node behind a virtual-TAP hub and connects the physical scan path to it. It does not toggle TMS or TCK itself. Instead it issues whole-scan commands to a separate scan engine. Each command is either an instruction scan or a data scan, with a bit length and a value to shift. The engine answers every command with a one-cycle completion pulse. For data scans it also returns the low four captured bits.

A `start` pulse runs the whole discovery on its own:

- It points the physical instruction register at the hub's virtual-instruction path and zeroes the hub address and instruction.
- It switches to the hub's data path and reads the hub configuration word as eight nibble scans.
- It reads one 32-bit info word per node, continuing the same run of nibble scans.
- It matches each node's ID field against a wanted value.

When a node matches, the block writes the selection word, built from the discovered layout, into the virtual instruction register. It then leaves the physical instruction register on the data path of the selected node. The discovered hub width fields, the node address and `done`/`error` flags stay on the outputs until the next `start`.

Top module: `vnode_enum`

## Requirements
- R1: After reset, `cmd_valid`, `done` and `error` are low and the sequencer waits for `start`.
- R2: After `start`, the first command is an instruction scan of `IR_LEN` bits with value `IR_SEL_HUB` (default 0x0E). The second is a data scan of `HUBSEL_LEN` (default 64) zero bits.
- R3: The third command is an instruction scan with value `IR_DATA_PATH` (default 0x0C). Eight 4-bit zero-valued data scans follow, and each captured nibble enters the top of a word that shifts right by four. The first nibble therefore ends in bits [3:0] and the eighth in bits [31:28].
- R4: From the hub word, `hub_nodes` is taken from bits [26:19] and `hub_m` from bits [7:0]. `hub_n` is the number of bits needed to hold `hub_nodes`, so 0 gives 0, 7 gives 3 and 8 gives 4.
- R5: For every node, eight more 4-bit data scans follow directly, with no instruction scan between nodes.
- R6: A node whose info-word bits [26:19] equal `WANTED_ID` (default 0x08) is a match, and its address is its 0-based position plus 1. When several nodes match, the address of the last one is reported on `found_addr`.
- R7: If no node matches, or the node count is 0, `error` rises, `done` stays low and no further command is issued.
- R8: On a match, three commands follow in order. First an instruction scan of `IR_SEL_HUB`. Then a data scan of `hub_n + hub_m` bits carrying `(found_addr << hub_m) | SEL_VIR` (default `SEL_VIR` 0x8). Last an instruction scan of `IR_DATA_PATH`. After that `done` rises.
- R9: A command stays valid with unchanged type, length and data until the cycle in which `scan_done` is seen.
- R10: `done` and `error` hold until the next `start`, which clears them in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a discovery run (accepted when not busy) |
| cmd_valid | output | 1 | A scan command is pending |
| cmd_is_ir | output | 1 | 1 = instruction scan, 0 = data scan |
| cmd_len | output | LEN_W | Number of bits to shift |
| cmd_data | output | DATA_W | Value to shift, LSB first |
| scan_done | input | 1 | One-cycle completion of the pending command |
| scan_tdo | input | 4 | Low four captured bits, valid with `scan_done` |
| found_addr | output | 8 | Hub address of the selected node |
| hub_m | output | 8 | Virtual instruction width from the hub word |
| hub_nodes | output | 8 | Node count from the hub word |
| hub_n | output | 4 | Address width derived from the node count |
| done | output | 1 | Selection finished |
| error | output | 1 | No matching node |

## Verification
Two events can land in the same cycle: the completion of the last nibble of the final node's info word, and the end-of-list decision. When the only match is the final node, the match must be recognised in the very cycle that chooses between selection and error. The bench provokes this with a hub of eight nodes whose last entry is the target, and with four nodes where both the first and last match. It judges the outcome from the exact command stream held in the scoreboard and from `found_addr`, `done` and `error`.

// File: rtl/vnode_enum.sv
module vnode_enum #(
  parameter int          IR_LEN       = 10,
  parameter int          HUBSEL_LEN   = 64,
  parameter int          DATA_W       = 64,
  parameter int          LEN_W        = 9,
  parameter logic [7:0]  WANTED_ID    = 8'h08,
  parameter logic [7:0]  SEL_VIR      = 8'h08,
  parameter int          IR_SEL_HUB   = 14,
  parameter int          IR_DATA_PATH = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              cmd_valid,
  output logic              cmd_is_ir,
  output logic [LEN_W-1:0]  cmd_len,
  output logic [DATA_W-1:0] cmd_data,
  input  logic              scan_done,
  input  logic [3:0]        scan_tdo,
  output logic [7:0]        found_addr,
  output logic [7:0]        hub_m,
  output logic [7:0]        hub_nodes,
  output logic [3:0]        hub_n,
  output logic              done,
  output logic              error
);

  typedef enum logic [3:0] {
    S_IDLE, S_IR1, S_HUBSEL, S_IR0, S_HUBNIB, S_NODENIB,
    S_SELIR1, S_SELDR, S_SELIR0, S_DONE, S_ERR
  } st_t;

  st_t         st;
  logic [31:0] word;
  logic [2:0]  nib;
  logic [7:0]  idx;
  logic        hit;

  wire        step     = cmd_valid & scan_done;
  wire [31:0] nxt_word = {scan_tdo, word[31:4]};
  wire        id_match = (nxt_word[26:19] == WANTED_ID);
  wire        last_nib = (nib == 3'd7);
  wire        idle_ok  = (st == S_IDLE) || (st == S_DONE) || (st == S_ERR);

  function automatic logic [3:0] bitlen(input logic [7:0] v);
    bitlen = 4'd0;
    for (int i = 0; i < 8; i++)
      if (v[i]) bitlen = 4'(i + 1);
  endfunction

  assign done  = (st == S_DONE);
  assign error = (st == S_ERR);

  always_comb begin
    cmd_valid = 1'b1;
    cmd_is_ir = 1'b0;
    cmd_len   = '0;
    cmd_data  = '0;
    case (st)
      S_IR1, S_SELIR1: begin
        cmd_is_ir = 1'b1;
        cmd_len   = LEN_W'(IR_LEN);
        cmd_data  = DATA_W'(IR_SEL_HUB);
      end
      S_IR0, S_SELIR0: begin
        cmd_is_ir = 1'b1;
        cmd_len   = LEN_W'(IR_LEN);
        cmd_data  = DATA_W'(IR_DATA_PATH);
      end
      S_HUBSEL:            cmd_len = LEN_W'(HUBSEL_LEN);
      S_HUBNIB, S_NODENIB: cmd_len = LEN_W'(4);
      S_SELDR: begin
        cmd_len  = LEN_W'(hub_n) + LEN_W'(hub_m);
        cmd_data = (DATA_W'(found_addr) << hub_m) | DATA_W'(SEL_VIR);
      end
      default: cmd_valid = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      word <= '0;
      nib <= '0;
      idx <= '0;
      hit <= 1'b0;
      found_addr <= '0;
      hub_m <= '0;
      hub_nodes <= '0;
      hub_n <= '0;
    end else if (idle_ok) begin
      if (start) begin
        st <= S_IR1;
        word <= '0;
        nib <= '0;
        idx <= '0;
        hit <= 1'b0;
        found_addr <= '0;
        hub_m <= '0;
        hub_nodes <= '0;
        hub_n <= '0;
      end
    end else if (step) begin
      case (st)
        S_IR1:    st <= S_HUBSEL;
        S_HUBSEL: st <= S_IR0;
        S_IR0:    st <= S_HUBNIB;
        S_HUBNIB: begin
          word <= nxt_word;
          nib  <= nib + 3'd1;
          if (last_nib) begin
            hub_nodes <= nxt_word[26:19];
            hub_m     <= nxt_word[7:0];
            hub_n     <= bitlen(nxt_word[26:19]);
            st        <= (nxt_word[26:19] == 8'd0) ? S_ERR : S_NODENIB;
          end
        end
        S_NODENIB: begin
          word <= nxt_word;
          nib  <= nib + 3'd1;
          if (last_nib) begin
            if (id_match) begin
              found_addr <= idx + 8'd1;
              hit        <= 1'b1;
            end
            if (idx == hub_nodes - 8'd1)
              st <= (hit || id_match) ? S_SELIR1 : S_ERR;
            else
              idx <= idx + 8'd1;
          end
        end
        S_SELIR1: st <= S_SELDR;
        S_SELDR:  st <= S_SELIR0;
        S_SELIR0: st <= S_DONE;
        default:  st <= S_IDLE;
      endcase
    end
  end

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !scan_done) |=> (cmd_valid && $stable(cmd_is_ir) && $stable(cmd_len) && $stable(cmd_data))); // R9

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (done || error) |-> !cmd_valid); // R7

  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error)); // R7

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done); // R10

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (error && !start) |=> error); // R10

  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (found_addr != 8'd0 && found_addr <= hub_nodes)); // R6

endmodule

// File: tb/sim_vnode_enum.sv
`timescale 1ns/1ps
module sim_vnode_enum;

  typedef struct packed {
    logic        ir;
    logic [15:0] len;
    logic [63:0] data;
  } cmd_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        cmd_valid, cmd_is_ir;
  logic [8:0]  cmd_len;
  logic [63:0] cmd_data;
  logic        scan_done = 1'b0;
  logic [3:0]  scan_tdo = 4'h0;
  logic [7:0]  found_addr, hub_m, hub_nodes;
  logic [3:0]  hub_n;
  logic        done, error;

  always #10 clk = ~clk;

  vnode_enum u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cmd_valid(cmd_valid), .cmd_is_ir(cmd_is_ir), .cmd_len(cmd_len), .cmd_data(cmd_data),
    .scan_done(scan_done), .scan_tdo(scan_tdo),
    .found_addr(found_addr), .hub_m(hub_m), .hub_nodes(hub_nodes), .hub_n(hub_n),
    .done(done), .error(error)
  );

  int n_run = 0;
  int n_fail = 0;
  cmd_t  q[$];
  string rq[$];
  logic [31:0] wlist [0:15];
  int nib_idx = 0;
  int lat = 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic exp_cmd(input logic ir, input int len, input logic [63:0] data, input string req);
    cmd_t c;
    c.ir = ir; c.len = 16'(len); c.data = data;
    q.push_back(c);
    rq.push_back(req);
  endtask

  // scan engine model and scoreboard monitor
  initial begin
    cmd_t got, e;
    string r;
    logic [31:0] w;
    forever begin
      @(negedge clk);
      if (rst_n && cmd_valid) begin
        got.ir = cmd_is_ir; got.len = 16'(cmd_len); got.data = cmd_data;
        if (q.size() == 0) begin
          chk(1'b0, "R7", "unexpected command len", 64'(cmd_len), 64'd0);
        end else begin
          e = q.pop_front();
          r = rq.pop_front();
          chk(got.ir == e.ir, r, "command type", 64'(got.ir), 64'(e.ir));
          chk(got.len == e.len, r, "command length", 64'(got.len), 64'(e.len));
          chk(got.data == e.data, r, "command data", got.data, e.data);
        end
        for (int d = 0; d < lat; d++) begin
          @(negedge clk);
          chk(cmd_valid && cmd_is_ir == got.ir && 16'(cmd_len) == got.len && cmd_data == got.data,
              "R9", "command held while pending", 64'(cmd_len), 64'(got.len));
        end
        if (!got.ir && got.len == 16'd4) begin
          w = wlist[nib_idx / 8] >> ((nib_idx % 8) * 4);
          scan_tdo = w[3:0];
          nib_idx++;
        end else begin
          scan_tdo = 4'h0;
        end
        scan_done = 1'b1;
        @(negedge clk);
        scan_done = 1'b0;
      end
    end
  end

  task automatic set_node(input int i, input logic [7:0] id);
    wlist[i] = {5'd2, id, 11'h06E, 8'(i)};
  endtask

  task automatic run(input int nn, input int mw, input int exp_addr, input int exp_n, input int l);
    lat = l;
    nib_idx = 0;
    q.delete();
    rq.delete();
    wlist[0] = {5'd1, 8'(nn), 11'h06E, 8'(mw)};
    exp_cmd(1'b1, 10, 64'h0E, "R2");
    exp_cmd(1'b0, 64, 64'h0, "R2");
    exp_cmd(1'b1, 10, 64'h0C, "R3");
    for (int i = 0; i < 8; i++) exp_cmd(1'b0, 4, 64'h0, "R3");
    for (int i = 0; i < 8 * nn; i++) exp_cmd(1'b0, 4, 64'h0, "R5");
    if (exp_addr > 0) begin
      exp_cmd(1'b1, 10, 64'h0E, "R8");
      exp_cmd(1'b0, exp_n + mw, (64'(exp_addr) << mw) | 64'h8, "R8");
      exp_cmd(1'b1, 10, 64'h0C, "R8");
    end
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(!done && !error, "R10", "flags cleared after start", {62'd0, done, error}, 64'd0);
    for (int t = 0; t < 5000 && !(done || error); t++) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(q.size() == 0, "R5", "expected commands left", 64'(q.size()), 64'd0);
    chk(done == (exp_addr > 0), "R8", "done", 64'(done), 64'(exp_addr > 0));
    chk(error == (exp_addr == 0), "R7", "error", 64'(error), 64'(exp_addr == 0));
    chk(!cmd_valid, "R7", "idle after finish", 64'(cmd_valid), 64'd0);
    if (exp_addr > 0)
      chk(found_addr == 8'(exp_addr), "R6", "found_addr", 64'(found_addr), 64'(exp_addr));
    chk(hub_nodes == 8'(nn), "R4", "hub_nodes", 64'(hub_nodes), 64'(nn));
    chk(hub_m == 8'(mw), "R4", "hub_m", 64'(hub_m), 64'(mw));
    chk(hub_n == 4'(exp_n), "R4", "hub_n", 64'(hub_n), 64'(exp_n));
    chk((done || error), "R10", "flag still held", {62'd0, done, error}, 64'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) wlist[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!cmd_valid && !done && !error, "R1", "reset state",
        {61'd0, cmd_valid, done, error}, 64'd0);

    // three nodes, target in the middle
    set_node(1, 8'h84); set_node(2, 8'h08); set_node(3, 8'h00);
    run(3, 4, 2, 2, 1);

    // no match
    set_node(1, 8'h04); set_node(2, 8'h00);
    run(2, 3, 0, 2, 0);

    // two matches, last kept; match on final node
    set_node(1, 8'h08); set_node(2, 8'h84); set_node(3, 8'h00); set_node(4, 8'h08);
    run(4, 5, 4, 3, 2);

    // empty hub
    run(0, 6, 0, 0, 1);

    // seven nodes, target first
    set_node(1, 8'h08);
    for (int i = 2; i <= 7; i++) set_node(i, 8'h84);
    run(7, 2, 1, 3, 0);

    // eight nodes, only the last matches
    for (int i = 1; i <= 7; i++) set_node(i, 8'h00);
    set_node(8, 8'h08);
    run(8, 8, 8, 4, 3);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule